// File: doc/BRIEF.md
# Ping-Pong Peripheral DMA Channel

This block is a single DMA channel that moves data between one peripheral and memory. It owns two buffer slots, each holding a start address and a byte count. The channel works on one slot at a time. When a slot runs out, it moves on to the other slot if that slot is armed, so software can refill the idle slot while the active one drains.

Software reaches the channel through a small register window. The control/status word has three views: one address ORs written ones into the word, one address clears the bits written as one, and one address reads the word. A configuration word holds the transfer direction, byte order, burst length, data width and peripheral routing.

Transfers are bursts of single-beat memory requests. A burst starts only while the peripheral's request line is high. An interrupt is raised on slot completion or on a setup error while interrupts are enabled.

Top module: `pp_dma_chan`

## Requirements
- R1: After reset the control word reads 0, the slot registers read 0, `irq` is low and `mem_req` is low.
- R2: Offset 0x04 sets the control bits written as 1, and offset 0x08 clears the control bits written as 1. Zeros in either write leave a bit unchanged. Offset 0x0C reads the word. The bit positions are RUN 0, IE 1, ERROR 2, DONE_A 3, START_A 4, DONE_B 5, START_B 6 and ACTIVE_B 7. The set view can only set RUN, IE, START_A and START_B. ACTIVE_B cannot be written. The config word at offset 0x00 reads back as written.
- R3: A burst is launched only when RUN is set, the START bit of the active slot is set, and `periph_req` is high. Otherwise `mem_req` stays low.
- R4: A burst has 4 beats when config bit 2 is 0 and 8 beats when it is 1. A burst stops early when the slot count reaches 0. `mem_req` drops between bursts.
- R5: With config bit 3 = 0, each beat moves a byte. With config bit 3 = 1, each beat moves a halfword. The count falls by the bytes moved and the address rises by the same amount. A halfword beat with only 1 byte left lowers the count by 1.
- R6: With config bit 0 = 1 (device to memory), each beat writes `periph_din` to memory and pulses `periph_pop`. With config bit 0 = 0, each beat reads memory and presents the data on `periph_dout` with `periph_push`. Byte beats use bits 7:0, with zeros in the upper byte.
- R7: For halfword beats, the memory byte at the lower address sits on data bits 7:0. When config bit 1 = 1 (big endian), the two bytes are swapped between memory and peripheral.
- R8: When the active slot's count reaches 0, its DONE bit is set and its START bit is cleared. If the other slot's START bit is set, ACTIVE_B switches to that slot and transfers continue. A running channel whose active slot is idle also switches to an armed other slot.
- R9: The slot start and count registers (A at 0x10/0x14, B at 0x18/0x1C) read back the current address and remaining count as the transfer advances.
- R10: Clearing RUN stops the channel after the beat in flight, and the slot registers keep their progress. Setting RUN again resumes from that address and count.
- R11: If a launch would start at an address with bits 1:0 nonzero, or with a count of 0, the channel sets ERROR, clears RUN and issues no memory request.
- R12: `irq` is high exactly while IE is set and at least one of ERROR, DONE_A or DONE_B is set.
- R13: Once `mem_req` is raised, it and `mem_addr` hold until `mem_ack` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_addr) |
| periph_req | input | 1 | Peripheral ready for a burst |
| periph_din | input | 16 | Data from peripheral (device to memory) |
| periph_pop | output | 1 | Peripheral data consumed this cycle |
| periph_dout | output | 16 | Data to peripheral (memory to device) |
| periph_push | output | 1 | periph_dout valid this cycle |
| periph_sel | output | 4 | Peripheral routing field, config bits 7:4 |
| mem_req | output | 1 | Memory beat request |
| mem_we | output | 1 | 1 = write beat, 0 = read beat |
| mem_size | output | 1 | 0 = byte, 1 = halfword |
| mem_addr | output | 32 | Beat byte address |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid with mem_ack |
| mem_ack | input | 1 | Beat accepted |
| irq | output | 1 | Interrupt |

## Verification
The bench goes after the hand-off from slot A to slot B in one armed run. A design that failed to clear START or to switch the active slot would stall there or repeat slot A's addresses. It pauses in the middle of a burst and resumes. A design that dropped progress on pause would replay beats, and the scoreboard would see a wrong address. It ends a halfword slot with one odd byte left, which catches a count that wraps instead of reaching zero. It also arms a misaligned address and a zero count, where a faulty design would issue memory traffic instead of raising ERROR.

// File: rtl/pp_dma_pkg.sv
// Package: shared offsets, control bit indices and helper types for the
// ping-pong DMA channel. Assumes exactly two buffer slots.
package pp_dma_pkg;
    localparam int NSLOT   = 2;
    localparam int CTRL_W  = 8;
    localparam int DATA_W  = 16;
    localparam int RADDR_W = 5;

    localparam logic [RADDR_W-1:0] OFS_CFG  = 5'h00;
    localparam logic [RADDR_W-1:0] OFS_SET  = 5'h04;
    localparam logic [RADDR_W-1:0] OFS_CLR  = 5'h08;
    localparam logic [RADDR_W-1:0] OFS_STAT = 5'h0C;
    localparam int SLOT_BASE   = 16;
    localparam int SLOT_STRIDE = 8;

    localparam int BIT_RUN     = 0;
    localparam int BIT_IE      = 1;
    localparam int BIT_ERR     = 2;
    localparam int BIT_DONE_A  = 3;
    localparam int BIT_START_A = 4;
    localparam int BIT_DONE_B  = 5;
    localparam int BIT_START_B = 6;
    localparam int BIT_ACT_B   = 7;

    localparam logic [CTRL_W-1:0] SW_SET_MASK = 8'h53;
    localparam logic [CTRL_W-1:0] SW_CLR_MASK = 8'h7F;

    typedef struct packed {
        logic wide;
        logic long_burst;
        logic big;
        logic dir_in;
    } xfer_cfg_t;

    typedef enum logic {ENG_IDLE = 1'b0, ENG_XFER = 1'b1} eng_state_e;

    // Places data on the lane order demanded by width and byte order.
    function automatic logic [DATA_W-1:0] lane_order(logic [DATA_W-1:0] d,
                                                     logic wide, logic big);
        if (!wide)
            return {8'h00, d[7:0]};
        else if (big)
            return {d[7:0], d[15:8]};
        else
            return d;
    endfunction
endpackage

// File: rtl/pp_dma_ctrl.sv
// Control/status word and config register. Applies software set/clear
// writes first, then engine events (completion, error), which override a
// same-cycle write. Assumes only one engine event per cycle.
module pp_dma_ctrl
    import pp_dma_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  sw_we,
    input  logic [RADDR_W-1:0]    sw_addr,
    input  logic [31:0]           sw_wdata,
    input  logic                  eng_idle,
    input  logic                  eng_done,
    input  logic                  eng_err,
    output logic [CTRL_W-1:0]     ctrl_q,
    output logic [31:0]           cfg_q
);
    logic [CTRL_W-1:0] ctrl_d;
    logic              cur_start;
    logic              oth_start;

    // Start bits of the active and idle slot as seen before this cycle.
    assign cur_start = ctrl_q[BIT_ACT_B] ? ctrl_q[BIT_START_B] : ctrl_q[BIT_START_A];
    assign oth_start = ctrl_q[BIT_ACT_B] ? ctrl_q[BIT_START_A] : ctrl_q[BIT_START_B];

    // Next control word: software edits, then slot hand-off, then error.
    always_comb begin
        ctrl_d = ctrl_q;
        if (sw_we && sw_addr == OFS_SET)
            ctrl_d = ctrl_d | (sw_wdata[CTRL_W-1:0] & SW_SET_MASK);
        if (sw_we && sw_addr == OFS_CLR)
            ctrl_d = ctrl_d & ~(sw_wdata[CTRL_W-1:0] & SW_CLR_MASK);
        if (eng_done) begin
            if (!ctrl_q[BIT_ACT_B]) begin
                ctrl_d[BIT_DONE_A]  = 1'b1;
                ctrl_d[BIT_START_A] = 1'b0;
                if (ctrl_d[BIT_START_B])
                    ctrl_d[BIT_ACT_B] = 1'b1;
            end else begin
                ctrl_d[BIT_DONE_B]  = 1'b1;
                ctrl_d[BIT_START_B] = 1'b0;
                if (ctrl_d[BIT_START_A])
                    ctrl_d[BIT_ACT_B] = 1'b0;
            end
        end else if (eng_idle && ctrl_q[BIT_RUN] && !cur_start && oth_start) begin
            ctrl_d[BIT_ACT_B] = ~ctrl_q[BIT_ACT_B];
        end
        if (eng_err) begin
            ctrl_d[BIT_RUN] = 1'b0;
            ctrl_d[BIT_ERR] = 1'b1;
        end
    end

    // Register the control word and the config word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            cfg_q  <= '0;
        end else begin
            ctrl_q <= ctrl_d;
            if (sw_we && sw_addr == OFS_CFG)
                cfg_q <= sw_wdata;
        end
    end
endmodule

// File: rtl/pp_dma_slots.sv
// Two buffer slots of start address and byte count. The engine updates the
// active slot after each beat; a software write to the same field in the
// same cycle takes the written value. Assumes ADDR_W <= 32.
module pp_dma_slots
    import pp_dma_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 13
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           sw_we,
    input  logic [RADDR_W-1:0]             sw_addr,
    input  logic [31:0]                    sw_wdata,
    input  logic                           upd_valid,
    input  logic                           upd_slot,
    input  logic [ADDR_W-1:0]              upd_addr,
    input  logic [CNT_W-1:0]               upd_cnt,
    output logic [NSLOT-1:0][ADDR_W-1:0]   slot_addr_q,
    output logic [NSLOT-1:0][CNT_W-1:0]    slot_cnt_q
);
    for (genvar g = 0; g < NSLOT; g++) begin : g_slot
        localparam logic [RADDR_W-1:0] A_OFS = RADDR_W'(SLOT_BASE + SLOT_STRIDE * g);
        localparam logic [RADDR_W-1:0] C_OFS = RADDR_W'(SLOT_BASE + SLOT_STRIDE * g + 4);

        // Hold one slot: engine progress, overridden by software writes.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slot_addr_q[g] <= '0;
                slot_cnt_q[g]  <= '0;
            end else begin
                if (upd_valid && upd_slot == 1'(g)) begin
                    slot_addr_q[g] <= upd_addr;
                    slot_cnt_q[g]  <= upd_cnt;
                end
                if (sw_we && sw_addr == A_OFS)
                    slot_addr_q[g] <= sw_wdata[ADDR_W-1:0];
                if (sw_we && sw_addr == C_OFS)
                    slot_cnt_q[g] <= sw_wdata[CNT_W-1:0];
            end
        end
    end
endmodule

// File: rtl/pp_dma_engine.sv
// Burst engine: checks the active slot at launch and raises an error on a
// misaligned address or a zero count. Otherwise it waits for the peripheral
// request and issues one beat per memory acknowledge, reporting progress
// to the slot store. Assumes mem_rdata is valid in the mem_ack cycle.
module pp_dma_engine
    import pp_dma_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int CNT_W       = 13,
    parameter int BURST_SHORT = 4,
    parameter int BURST_LONG  = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run,
    input  xfer_cfg_t          cfg,
    input  logic               act_start,
    input  logic [ADDR_W-1:0]  act_addr,
    input  logic [CNT_W-1:0]   act_cnt,
    input  logic               periph_req,
    input  logic [DATA_W-1:0]  periph_din,
    input  logic               mem_ack,
    input  logic [DATA_W-1:0]  mem_rdata,
    output logic               mem_req,
    output logic               mem_we,
    output logic               mem_size,
    output logic [ADDR_W-1:0]  mem_addr,
    output logic [DATA_W-1:0]  mem_wdata,
    output logic               periph_pop,
    output logic               periph_push,
    output logic [DATA_W-1:0]  periph_dout,
    output logic               upd_valid,
    output logic [ADDR_W-1:0]  upd_addr,
    output logic [CNT_W-1:0]   upd_cnt,
    output logic               done_evt,
    output logic               err_evt,
    output logic               idle
);
    localparam int BEAT_W = $clog2(BURST_LONG + 1);

    eng_state_e        state_q;
    logic [BEAT_W-1:0] beats_q;
    logic [CNT_W-1:0]  step;
    logic              bad_setup;
    logic              launch;
    logic              beat_ok;

    // Launch qualification and the per-beat address/count step.
    always_comb begin
        idle      = (state_q == ENG_IDLE);
        bad_setup = (act_cnt == '0) || (act_addr[1:0] != 2'b00);
        err_evt   = idle && run && act_start && bad_setup;
        launch    = idle && run && act_start && !bad_setup && periph_req;
        beat_ok   = (state_q == ENG_XFER) && mem_ack;
        step      = (cfg.wide && act_cnt != CNT_W'(1)) ? CNT_W'(2) : CNT_W'(1);
        upd_valid = beat_ok;
        upd_cnt   = (act_cnt > step) ? act_cnt - step : '0;
        upd_addr  = act_addr + ADDR_W'(step);
        done_evt  = beat_ok && (upd_cnt == '0);
    end

    // Memory and peripheral side signals of the current beat.
    always_comb begin
        mem_req     = (state_q == ENG_XFER);
        mem_we      = cfg.dir_in;
        mem_size    = cfg.wide;
        mem_addr    = act_addr;
        mem_wdata   = lane_order(periph_din, cfg.wide, cfg.big);
        periph_dout = lane_order(mem_rdata, cfg.wide, cfg.big);
        periph_pop  = beat_ok && cfg.dir_in;
        periph_push = beat_ok && !cfg.dir_in;
    end

    // Burst state: load the beat budget at launch, end on budget, count or pause.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ENG_IDLE;
            beats_q <= '0;
        end else begin
            case (state_q)
                ENG_IDLE: begin
                    if (launch) begin
                        state_q <= ENG_XFER;
                        beats_q <= cfg.long_burst ? BEAT_W'(BURST_LONG) : BEAT_W'(BURST_SHORT);
                    end
                end
                ENG_XFER: begin
                    if (beat_ok) begin
                        beats_q <= beats_q - BEAT_W'(1);
                        if (done_evt || beats_q == BEAT_W'(1) || !run)
                            state_q <= ENG_IDLE;
                    end
                end
                default: state_q <= ENG_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/pp_dma_chan.sv
// Top of the ping-pong DMA channel: ties the control word, the slot store
// and the burst engine together. It also provides the register read mux
// and the interrupt. Assumes ADDR_W <= 32 and CNT_W <= 32.
module pp_dma_chan
    import pp_dma_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int CNT_W       = 13,
    parameter int BURST_SHORT = 4,
    parameter int BURST_LONG  = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_we,
    input  logic [4:0]         reg_addr,
    input  logic [31:0]        reg_wdata,
    output logic [31:0]        reg_rdata,
    input  logic               periph_req,
    input  logic [15:0]        periph_din,
    output logic               periph_pop,
    output logic [15:0]        periph_dout,
    output logic               periph_push,
    output logic [3:0]         periph_sel,
    output logic               mem_req,
    output logic               mem_we,
    output logic               mem_size,
    output logic [ADDR_W-1:0]  mem_addr,
    output logic [15:0]        mem_wdata,
    input  logic [15:0]        mem_rdata,
    input  logic               mem_ack,
    output logic               irq
);
    logic [CTRL_W-1:0]            ctrl_q;
    logic [31:0]                  cfg_q;
    logic [NSLOT-1:0][ADDR_W-1:0] slot_addr_q;
    logic [NSLOT-1:0][CNT_W-1:0]  slot_cnt_q;
    logic                         eng_idle;
    logic                         eng_done;
    logic                         eng_err;
    logic                         upd_valid;
    logic [ADDR_W-1:0]            upd_addr;
    logic [CNT_W-1:0]             upd_cnt;
    logic                         act_b;
    logic                         act_start;
    xfer_cfg_t                    xcfg;

    assign act_b      = ctrl_q[BIT_ACT_B];
    assign act_start  = act_b ? ctrl_q[BIT_START_B] : ctrl_q[BIT_START_A];
    assign xcfg       = xfer_cfg_t'(cfg_q[3:0]);
    assign periph_sel = cfg_q[7:4];

    pp_dma_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .sw_we    (reg_we),
        .sw_addr  (reg_addr),
        .sw_wdata (reg_wdata),
        .eng_idle (eng_idle),
        .eng_done (eng_done),
        .eng_err  (eng_err),
        .ctrl_q   (ctrl_q),
        .cfg_q    (cfg_q)
    );

    pp_dma_slots #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_slots (
        .clk         (clk),
        .rst_n       (rst_n),
        .sw_we       (reg_we),
        .sw_addr     (reg_addr),
        .sw_wdata    (reg_wdata),
        .upd_valid   (upd_valid),
        .upd_slot    (act_b),
        .upd_addr    (upd_addr),
        .upd_cnt     (upd_cnt),
        .slot_addr_q (slot_addr_q),
        .slot_cnt_q  (slot_cnt_q)
    );

    pp_dma_engine #(
        .ADDR_W(ADDR_W), .CNT_W(CNT_W),
        .BURST_SHORT(BURST_SHORT), .BURST_LONG(BURST_LONG)
    ) u_eng (
        .clk         (clk),
        .rst_n       (rst_n),
        .run         (ctrl_q[BIT_RUN]),
        .cfg         (xcfg),
        .act_start   (act_start),
        .act_addr    (slot_addr_q[act_b]),
        .act_cnt     (slot_cnt_q[act_b]),
        .periph_req  (periph_req),
        .periph_din  (periph_din),
        .mem_ack     (mem_ack),
        .mem_rdata   (mem_rdata),
        .mem_req     (mem_req),
        .mem_we      (mem_we),
        .mem_size    (mem_size),
        .mem_addr    (mem_addr),
        .mem_wdata   (mem_wdata),
        .periph_pop  (periph_pop),
        .periph_push (periph_push),
        .periph_dout (periph_dout),
        .upd_valid   (upd_valid),
        .upd_addr    (upd_addr),
        .upd_cnt     (upd_cnt),
        .done_evt    (eng_done),
        .err_evt     (eng_err),
        .idle        (eng_idle)
    );

    // Register read mux; all three control views return the word.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            OFS_CFG:                    reg_rdata = cfg_q;
            OFS_SET, OFS_CLR, OFS_STAT: reg_rdata = 32'(ctrl_q);
            5'h10:                      reg_rdata = 32'(slot_addr_q[0]);
            5'h14:                      reg_rdata = 32'(slot_cnt_q[0]);
            5'h18:                      reg_rdata = 32'(slot_addr_q[1]);
            5'h1C:                      reg_rdata = 32'(slot_cnt_q[1]);
            default:                    reg_rdata = '0;
        endcase
    end

    // Interrupt: enabled and any completion or error flag pending.
    assign irq = ctrl_q[BIT_IE] &&
                 (ctrl_q[BIT_ERR] || ctrl_q[BIT_DONE_A] || ctrl_q[BIT_DONE_B]);
endmodule

// File: rtl/pp_dma_chan_chk.sv
// Checker for the ping-pong DMA channel, bound into the top. It observes
// the handshake, launch gating, slot completion and error handling.
module pp_dma_chan_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              run,
    input logic              err,
    input logic              done_a,
    input logic              start_a,
    input logic              done_b,
    input logic              start_b,
    input logic              act_b,
    input logic              mem_req,
    input logic              mem_ack,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              periph_req,
    input logic              eng_done,
    input logic              eng_err
);
    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr)); // R13

    AST_LAUNCH_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_req) |-> $past(periph_req) && $past(run)); // R3

    AST_STOPPED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !run && !mem_req |=> !mem_req); // R10

    AST_ERR_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
        eng_err |=> err && !run); // R11

    AST_DONE_A_MARKS: assert property (@(posedge clk) disable iff (!rst_n)
        eng_done && !act_b |=> done_a && !start_a); // R8

    AST_DONE_B_MARKS: assert property (@(posedge clk) disable iff (!rst_n)
        eng_done && act_b |=> done_b && !start_b); // R8
endmodule

bind pp_dma_chan pp_dma_chan_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (ctrl_q[0]),
    .err        (ctrl_q[2]),
    .done_a     (ctrl_q[3]),
    .start_a    (ctrl_q[4]),
    .done_b     (ctrl_q[5]),
    .start_b    (ctrl_q[6]),
    .act_b      (ctrl_q[7]),
    .mem_req    (mem_req),
    .mem_ack    (mem_ack),
    .mem_addr   (mem_addr),
    .periph_req (periph_req),
    .eng_done   (eng_done),
    .eng_err    (eng_err)
);

// File: tb/pp_dma_chan_test.sv
`timescale 1ns/1ps
module pp_dma_chan_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        periph_req = 1'b0;
    logic [15:0] periph_din;
    logic        periph_pop, periph_push;
    logic [15:0] periph_dout;
    logic [3:0]  periph_sel;
    logic        mem_req, mem_we, mem_size;
    logic [31:0] mem_addr;
    logic [15:0] mem_wdata;
    logic [15:0] mem_rdata;
    logic        mem_ack;
    logic        irq;

    always #2 clk = ~clk;

    pp_dma_chan uut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .periph_req(periph_req),
        .periph_din(periph_din), .periph_pop(periph_pop), .periph_dout(periph_dout),
        .periph_push(periph_push), .periph_sel(periph_sel), .mem_req(mem_req),
        .mem_we(mem_we), .mem_size(mem_size), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack), .irq(irq)
    );

    int n_cmp = 0;
    int n_bad = 0;
    int n_rise = 0;
    bit req_prev = 1'b0;
    bit ended = 1'b0;
    logic [15:0] src_q;
    logic [15:0] exp_src = 16'h1000;

    typedef struct packed {
        logic        we;
        logic [31:0] addr;
        logic [15:0] data;
    } beat_t;
    beat_t exp_q[$];
    string tag_q[$];

    function automatic logic [7:0] mbyte(logic [31:0] a);
        return 8'(a * 7 + 32'h31);
    endfunction

    // Memory model: acknowledges one cycle after a request, data from address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_ack   <= 1'b0;
            mem_rdata <= '0;
        end else begin
            mem_ack   <= mem_req && !mem_ack;
            mem_rdata <= {mbyte(mem_addr + 1), mbyte(mem_addr)};
        end
    end

    // Peripheral source: a counting data stream advanced on each pop.
    always_ff @(posedge clk) begin
        if (!rst_n) src_q <= 16'h1000;
        else if (periph_pop) src_q <= src_q + 16'h0101;
    end
    assign periph_din = src_q;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Monitor: pops expected beats and compares them with each acknowledged beat.
    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_req && !req_prev) n_rise++;
            req_prev = mem_req;
            if (mem_req && mem_ack) begin
                n_cmp++;
                if (exp_q.size() == 0) begin
                    n_bad++;
                    $display("FAIL R3 unexpected beat: actual addr %h expected none", mem_addr);
                end else begin
                    beat_t it;
                    string tg;
                    it = exp_q.pop_front();
                    tg = tag_q.pop_front();
                    if (mem_addr !== it.addr || mem_we !== it.we) begin
                        n_bad++;
                        $display("FAIL %s beat: actual addr %h we %b expected addr %h we %b",
                                 tg, mem_addr, mem_we, it.addr, it.we);
                    end else if (it.we && mem_wdata !== it.data) begin
                        n_bad++;
                        $display("FAIL %s write data: actual %h expected %h", tg, mem_wdata, it.data);
                    end else if (!it.we && (periph_push !== 1'b1 || periph_dout !== it.data)) begin
                        n_bad++;
                        $display("FAIL %s peripheral data: actual %h push %b expected %h",
                                 tg, periph_dout, periph_push, it.data);
                    end
                end
            end
        end
    end

    // Driver: pushes the expected beats of one slot run.
    task automatic expect_run(input string tag, input logic we, input logic [31:0] base,
                              input int nbytes, input logic wide, input logic big);
        int rem = nbytes;
        logic [31:0] a = base;
        while (rem > 0) begin
            int st = (!wide) ? 1 : ((rem >= 2) ? 2 : 1);
            logic [15:0] d;
            logic [15:0] m;
            if (we) begin
                d = exp_src;
                exp_src = exp_src + 16'h0101;
            end else begin
                d = {mbyte(a + 1), mbyte(a)};
            end
            if (!wide) m = {8'h00, d[7:0]};
            else if (big) m = {d[7:0], d[15:8]};
            else m = d;
            exp_q.push_back('{we: we, addr: a, data: m});
            tag_q.push_back(tag);
            a = a + 32'(st);
            rem = rem - st;
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic rdchk(input string tag, input logic [4:0] a, input logic [31:0] exp);
        logic [31:0] d;
        rd(a, d);
        chk(tag, d, exp);
    endtask

    task automatic drain(input string tag);
        int t = 0;
        while (exp_q.size() != 0 && t < 2000) begin
            @(negedge clk);
            t++;
        end
        chk({tag, " all beats seen"}, 32'(exp_q.size()), 32'd0);
        repeat (4) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        rdchk("R1 control", 5'h0C, 32'h0);
        rdchk("R1 slot A addr", 5'h10, 32'h0);
        chk("R1 irq", 32'(irq), 32'h0);
        chk("R1 mem_req", 32'(mem_req), 32'h0);

        // R2: set/clear views and config readback
        wr(5'h04, 32'h02);  rdchk("R2 set IE", 5'h0C, 32'h02);
        wr(5'h04, 32'h00);  rdchk("R2 zero set", 5'h0C, 32'h02);
        wr(5'h04, 32'hAC);  rdchk("R2 masked set", 5'h0C, 32'h02);
        wr(5'h08, 32'h00);  rdchk("R2 zero clear", 5'h0C, 32'h02);
        wr(5'h08, 32'h02);  rdchk("R2 clear IE", 5'h08, 32'h00);
        wr(5'h00, 32'hABCD_E0F5); rdchk("R2 config", 5'h00, 32'hABCD_E0F5);
        chk("R2 periph_sel", 32'(periph_sel), 32'hF);

        // R3/R6: device to memory, bytes, 4-beat bursts, held off by periph_req
        wr(5'h00, 32'h01);
        wr(5'h10, 32'h40);
        wr(5'h14, 32'd6);
        expect_run("R6", 1'b1, 32'h40, 6, 1'b0, 1'b0);
        n_rise = 0;
        wr(5'h04, 32'h13);
        repeat (10) @(negedge clk);
        chk("R3 no request without periph_req", 32'(mem_req), 32'h0);
        periph_req = 1'b1;
        wait (mem_req);
        @(negedge clk);
        chk("R13 first beat waiting", 32'({mem_req, mem_ack}), 32'h2);
        @(negedge clk);
        chk("R13 request held", 32'(mem_req), 32'h1);
        chk("R13 address held", mem_addr, 32'h40);
        drain("R6");
        chk("R4 two bursts of 4 for 6 bytes", 32'(n_rise), 32'd2);
        rdchk("R8 slot A done", 5'h0C, 32'h0B);
        chk("R12 irq on done", 32'(irq), 32'h1);
        rdchk("R9 A address", 5'h10, 32'h46);
        rdchk("R9 A count", 5'h14, 32'h0);
        wr(5'h08, 32'h08);
        chk("R12 irq after clear", 32'(irq), 32'h0);

        // R7/R8: memory to device, halfword big endian, 8-beat, A then B
        wr(5'h08, 32'h7F);
        wr(5'h00, 32'h0E);
        wr(5'h10, 32'h80);  wr(5'h14, 32'd4);
        wr(5'h18, 32'hC0);  wr(5'h1C, 32'd3);
        expect_run("R7", 1'b0, 32'h80, 4, 1'b1, 1'b1);
        expect_run("R7", 1'b0, 32'hC0, 3, 1'b1, 1'b1);
        n_rise = 0;
        wr(5'h04, 32'h53);
        drain("R7");
        rdchk("R8 hand-off to B and both done", 5'h0C, 32'hAB);
        rdchk("R5 odd halfword end address", 5'h18, 32'hC3);
        rdchk("R5 B count", 5'h1C, 32'h0);
        chk("R4 one burst per slot", 32'(n_rise), 32'd2);
        wr(5'h08, 32'h28);
        chk("R12 irq cleared", 32'(irq), 32'h0);

        // R10: pause mid-burst, then resume; halfword little endian
        wr(5'h08, 32'h7F);
        wr(5'h00, 32'h09);
        wr(5'h10, 32'h100); wr(5'h14, 32'd16);
        expect_run("R10", 1'b1, 32'h100, 16, 1'b1, 1'b0);
        n_rise = 0;
        wr(5'h04, 32'h11);
        wait (mem_ack);
        wr(5'h08, 32'h01);
        repeat (20) @(negedge clk);
        chk("R10 stopped", 32'(mem_req), 32'h0);
        rdchk("R10 count kept", 5'h14, 32'd12);
        rdchk("R10 address kept", 5'h10, 32'h104);
        chk("R10 beats left", 32'(exp_q.size()), 32'd6);
        wr(5'h04, 32'h01);
        drain("R10");
        chk("R4 bursts with pause", 32'(n_rise), 32'd3);
        rdchk("R10 finished", 5'h0C, 32'h09);

        // R11: misaligned start, then zero count
        wr(5'h08, 32'h7F);
        wr(5'h00, 32'h01);
        wr(5'h10, 32'h202); wr(5'h14, 32'd4);
        n_rise = 0;
        wr(5'h04, 32'h11);
        repeat (5) @(negedge clk);
        rdchk("R11 misaligned error", 5'h0C, 32'h14);
        wr(5'h08, 32'h04);
        wr(5'h10, 32'h200); wr(5'h14, 32'd0);
        wr(5'h04, 32'h01);
        repeat (5) @(negedge clk);
        rdchk("R11 zero count error", 5'h0C, 32'h14);
        chk("R11 no memory traffic", 32'(n_rise), 32'd0);
        wr(5'h04, 32'h02);
        chk("R12 irq on error", 32'(irq), 32'h1);

        repeat (5) @(negedge clk);
        finish_run();
    end
endmodule